// File: doc/BRIEF.md
# SD Card SPI Command Engine

This block issues single commands to an SD or MMC card operating in SPI mode and collects the card's short reply. It sits between a card-initialisation sequencer and a byte-wide SPI shifter. For every command it emits a leading filler byte, a six-byte frame (start and transmission bits, command index, 32-bit argument, CRC7 with an end bit), then clocks filler bytes while polling for the one-byte R1 status. When asked, it also reads four further bytes and assembles them into a 32-bit word, as needed for the interface-condition and operating-conditions reads.

After reset, and before any command is accepted, the engine sends a run of idle bytes with the card deselected and the data line high, so the card sees well over 74 clocks. Each completed command yields R1, the optional 32-bit word and a two-bit error class (none, no response, CRC fault, other fault), all valid in the cycle that `done` pulses.

The controller is a single state machine. States: PRE (power-up idle bytes), IDLE (waiting for `start`), FRAME (seven outgoing bytes), POLL (reading for R1), EXTRA (four trailing reply bytes), TAIL (deselected filler byte) and FINISH (one-cycle completion). Transitions: PRE to IDLE after the last idle byte; IDLE to FRAME on `start`; FRAME to POLL after the seventh byte; POLL to EXTRA when a clean R1 arrives and the long reply is selected; POLL to TAIL when any other R1 arrives or the poll budget runs out; EXTRA to TAIL after the fourth byte; TAIL to FINISH after the filler byte; FINISH to IDLE unconditionally.

Top module: `sdspi_cmd_engine`

## Requirements
- R1: After reset the engine performs PRE_BYTES (default 10) byte transfers, each sending 0xFF with `xfer_sel` low; `ready` stays low until they finish and is high only in IDLE, where no transfer is requested.
- R2: A command begins with one 0xFF byte and then six bytes, all with `xfer_sel` high: 0x40 OR the 6-bit index, then the argument most significant byte first. A requested byte's value and select stay unchanged until `xfer_ack`.
- R3: With `crc_on` high, the sixth frame byte is the CRC7 (polynomial x^7+x^3+1, initial value zero) over the five preceding frame bytes, placed in bits 7:1, with bit 0 set to 1.
- R4: With `crc_on` low, the sixth frame byte is the constant 0x95 for every command.
- R5: During polling the engine sends 0xFF; the first polled byte is always discarded, and the first later byte with bit 7 clear is taken as R1, ending the poll.
- R6: If none of the POLL_LIMIT (default 8) polled bytes yields R1, the reported R1 is 0xFF and the class is timeout (1); a reported R1 is always either 0xFF or has bit 7 clear.
- R7: Class encoding: 0 none, 1 timeout, 2 CRC fault when R1 bit 3 is set, 3 other fault when any of R1 bits 7:1 is set but bit 3 is not; bit 0 (idle) alone is no fault.
- R8: When `long_resp` is high and R1 has bits 7:1 clear, four more 0xFF bytes are clocked with select high and the received bytes form `resp_word` most significant first; otherwise no extra bytes are clocked and `resp_word` is zero.
- R9: Every command ends with exactly TAIL_BYTES (default 1) 0xFF bytes with `xfer_sel` low, after which `done` pulses for one cycle with results valid.
- R10: A `start` pulse while a command is in progress is ignored and does not alter the byte stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a command (honoured only when ready) |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| long_resp | input | 1 | Read four extra reply bytes after a clean R1 |
| crc_on | input | 1 | 1: computed CRC7, 0: fixed 0x95 |
| ready | output | 1 | Idle and able to accept start |
| busy | output | 1 | Preamble or command in progress |
| done | output | 1 | One-cycle completion pulse |
| r1 | output | 8 | Captured R1 status |
| resp_word | output | 32 | Extra reply word |
| err_class | output | 2 | Decoded error class |
| xfer_req | output | 1 | Byte transfer request to the shifter |
| xfer_tx | output | 8 | Byte to send |
| xfer_sel | output | 1 | Card select, high = selected |
| xfer_ack | input | 1 | Shifter finished the requested byte |
| xfer_rx | input | 8 | Byte received with the ack |

## Verification
On every cycle the assertions hold the byte handshake stable until acknowledged, force 0xFF whenever the card is deselected, keep IDLE free of transfers, bound the poll counter, keep the completion pulse to one cycle, and tie a reported R1 and a faulted class to their legal shapes. Only the bench scenarios can show the exact byte order of each frame, the CRC values of specific commands, the discarding of the first polled byte, the chosen R1 among several candidates, the extra-word assembly and the immunity to a stray start, since these depend on the card's scripted replies.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

    localparam int FRAME_LEN  = 7;
    localparam int RESP_BYTES = 4;

    typedef enum logic [2:0] {
        ST_PRE, ST_IDLE, ST_FRAME, ST_POLL, ST_EXTRA, ST_TAIL, ST_FINISH
    } eng_state_e;

    typedef enum logic [1:0] {
        CLS_NONE    = 2'd0,
        CLS_TIMEOUT = 2'd1,
        CLS_CRC     = 2'd2,
        CLS_OTHER   = 2'd3
    } err_class_e;

    // Bit-serial CRC7, generator x^7 + x^3 + 1, register starts at zero.
    function automatic logic [6:0] crc7_of40(input logic [39:0] msg);
        logic [6:0] acc;
        logic       fb;
        acc = '0;
        for (int i = 39; i >= 0; i--) begin
            fb  = msg[i] ^ acc[6];
            acc = {acc[5:0], 1'b0};
            if (fb) acc = acc ^ 7'h09;
        end
        return acc;
    endfunction

endpackage

// File: rtl/sdspi_frame.sv
module sdspi_frame
    import sdspi_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic [5:0]       index,
    input  logic [31:0]      arg,
    input  logic             crc_on,
    input  logic [SEL_W-1:0] sel,
    output logic [7:0]       frame_byte
);
    localparam logic [7:0] FIXED_CRC = 8'h95;

    logic [7:0] slot [FRAME_LEN];
    logic [6:0] crc;

    assign crc = crc7_of40({2'b01, index, arg});

    assign slot[0] = 8'hFF;
    assign slot[1] = {2'b01, index};

    genvar g;
    generate
        for (g = 0; g < RESP_BYTES; g++) begin : g_arg
            assign slot[2+g] = arg[31-8*g -: 8];
        end
    endgenerate

    assign slot[FRAME_LEN-1] = crc_on ? {crc, 1'b1} : FIXED_CRC;

    always_comb begin
        frame_byte = 8'hFF;
        for (int i = 0; i < FRAME_LEN; i++) begin
            if (sel == SEL_W'(i)) frame_byte = slot[i];
        end
    end
endmodule

// File: rtl/sdspi_classify.sv
module sdspi_classify
    import sdspi_pkg::*;
(
    input  logic [7:0]  r1,
    output err_class_e  cls
);
    always_comb begin
        if (r1 == 8'hFF)        cls = CLS_TIMEOUT;
        else if (r1[3])         cls = CLS_CRC;
        else if (|r1[7:1])      cls = CLS_OTHER;
        else                    cls = CLS_NONE;
    end
endmodule

// File: rtl/sdspi_step_ctr.sv
module sdspi_step_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (clr)   count <= '0;
        else if (inc)   count <= count + 1'b1;
    end
endmodule

// File: rtl/sdspi_cmd_engine.sv
module sdspi_cmd_engine
    import sdspi_pkg::*;
#(
    parameter int PRE_BYTES  = 10,
    parameter int POLL_LIMIT = 8,
    parameter int TAIL_BYTES = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [5:0]  cmd_index,
    input  logic [31:0] cmd_arg,
    input  logic        long_resp,
    input  logic        crc_on,
    output logic        ready,
    output logic        busy,
    output logic        done,
    output logic [7:0]  r1,
    output logic [31:0] resp_word,
    output logic [1:0]  err_class,
    output logic        xfer_req,
    output logic [7:0]  xfer_tx,
    output logic        xfer_sel,
    input  logic        xfer_ack,
    input  logic [7:0]  xfer_rx
);
    localparam int MAX_A = (PRE_BYTES > POLL_LIMIT) ? PRE_BYTES : POLL_LIMIT;
    localparam int MAX_B = (FRAME_LEN > TAIL_BYTES) ? FRAME_LEN : TAIL_BYTES;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam int SEL_W = $clog2(FRAME_LEN + 1);

    eng_state_e  state, state_n;
    logic [CNT_W-1:0] cnt;
    logic        cnt_clr, cnt_inc;
    logic [5:0]  idx_q;
    logic [31:0] arg_q;
    logic        long_q, crc_q;
    logic [7:0]  r1_q;
    logic [31:0] resp_q;
    logic [7:0]  frame_byte;
    logic        poll_hit;
    err_class_e  cls;

    sdspi_step_ctr #(.W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .count(cnt)
    );

    sdspi_frame #(.SEL_W(SEL_W)) u_frame (
        .index(idx_q), .arg(arg_q), .crc_on(crc_q),
        .sel(SEL_W'(cnt)), .frame_byte(frame_byte)
    );

    sdspi_classify u_cls (.r1(r1_q), .cls(cls));

    assign poll_hit = (cnt != '0) && !xfer_rx[7];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PRE;
        else        state <= state_n;
    end

    // Next state and counter control
    always_comb begin
        state_n = state;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state)
            ST_PRE: if (xfer_ack) begin
                if (cnt == CNT_W'(PRE_BYTES - 1)) begin
                    state_n = ST_IDLE; cnt_clr = 1'b1;
                end else cnt_inc = 1'b1;
            end
            ST_IDLE: if (start) begin
                state_n = ST_FRAME; cnt_clr = 1'b1;
            end
            ST_FRAME: if (xfer_ack) begin
                if (cnt == CNT_W'(FRAME_LEN - 1)) begin
                    state_n = ST_POLL; cnt_clr = 1'b1;
                end else cnt_inc = 1'b1;
            end
            ST_POLL: if (xfer_ack) begin
                if (poll_hit) begin
                    cnt_clr = 1'b1;
                    state_n = (long_q && (xfer_rx[7:1] == 7'd0)) ? ST_EXTRA : ST_TAIL;
                end else if (cnt == CNT_W'(POLL_LIMIT - 1)) begin
                    state_n = ST_TAIL; cnt_clr = 1'b1;
                end else cnt_inc = 1'b1;
            end
            ST_EXTRA: if (xfer_ack) begin
                if (cnt == CNT_W'(RESP_BYTES - 1)) begin
                    state_n = ST_TAIL; cnt_clr = 1'b1;
                end else cnt_inc = 1'b1;
            end
            ST_TAIL: if (xfer_ack) begin
                if (cnt == CNT_W'(TAIL_BYTES - 1)) begin
                    state_n = ST_FINISH; cnt_clr = 1'b1;
                end else cnt_inc = 1'b1;
            end
            ST_FINISH: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // Command latch and reply capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            arg_q  <= '0;
            long_q <= 1'b0;
            crc_q  <= 1'b0;
            r1_q   <= 8'hFF;
            resp_q <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                idx_q  <= cmd_index;
                arg_q  <= cmd_arg;
                long_q <= long_resp;
                crc_q  <= crc_on;
                r1_q   <= 8'hFF;
                resp_q <= '0;
            end
            if (state == ST_POLL && xfer_ack && poll_hit) r1_q <= xfer_rx;
            if (state == ST_EXTRA && xfer_ack) resp_q <= {resp_q[23:0], xfer_rx};
        end
    end

    // Outputs
    always_comb begin
        xfer_req = 1'b0;
        xfer_sel = 1'b0;
        xfer_tx  = 8'hFF;
        unique case (state)
            ST_PRE, ST_TAIL: xfer_req = 1'b1;
            ST_FRAME: begin
                xfer_req = 1'b1; xfer_sel = 1'b1; xfer_tx = frame_byte;
            end
            ST_POLL, ST_EXTRA: begin
                xfer_req = 1'b1; xfer_sel = 1'b1;
            end
            default: ;
        endcase
        ready     = (state == ST_IDLE);
        busy      = (state != ST_IDLE);
        done      = (state == ST_FINISH);
        r1        = r1_q;
        resp_word = resp_q;
        err_class = cls;
    end

    // Checks
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_tx) && $stable(xfer_sel));

    assert_deselect_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_sel |-> xfer_tx == 8'hFF);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_r1_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!r1[7] || r1 == 8'hFF));

    assert_resp_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done && err_class != 2'd0 |-> resp_word == 32'd0);

    assert_ready_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !xfer_req && !xfer_sel);

    assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_POLL |-> cnt < CNT_W'(POLL_LIMIT));
endmodule

// File: tb/tb_sdspi_cmd_engine.sv
module tb_sdspi_cmd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic        long_resp = 1'b0;
    logic        crc_on = 1'b0;
    logic        ready, busy, done;
    logic [7:0]  r1;
    logic [31:0] resp_word;
    logic [1:0]  err_class;
    logic        xfer_req, xfer_sel;
    logic [7:0]  xfer_tx;
    logic        xfer_ack = 1'b0;
    logic [7:0]  xfer_rx = 8'hFF;

    int errors = 0;
    int checks = 0;

    logic [8:0]  exp_q[$];
    string       exp_tag[$];
    logic [7:0]  script [12];
    int          script_len = 0;

    sdspi_cmd_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .long_resp(long_resp), .crc_on(crc_on),
        .ready(ready), .busy(busy), .done(done), .r1(r1), .resp_word(resp_word),
        .err_class(err_class), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
        .xfer_sel(xfer_sel), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic sel, input logic [7:0] b, input string tag);
        exp_q.push_back({sel, b});
        exp_tag.push_back(tag);
    endtask

    // Monitor / shifter model: pops expected bytes and replies from the script.
    initial begin
        int sel_cnt = 0;
        logic [7:0] rx;
        logic [8:0] e;
        string tag;
        forever begin
            @(negedge clk);
            if (rst_n && xfer_req) begin
                if (exp_q.size() == 0) begin
                    chk("R10 unexpected byte", {23'd0, xfer_sel, xfer_tx}, 32'h1FF);
                end else begin
                    e = exp_q.pop_front();
                    tag = exp_tag.pop_front();
                    chk(tag, {23'd0, xfer_sel, xfer_tx}, {23'd0, e});
                end
                if (xfer_sel) begin
                    rx = (sel_cnt >= 7 && sel_cnt - 7 < script_len) ? script[sel_cnt-7] : 8'hFF;
                    sel_cnt++;
                end else begin
                    rx = 8'hFF;
                    sel_cnt = 0;
                end
                @(negedge clk);
                xfer_ack = 1'b1;
                xfer_rx  = rx;
                @(negedge clk);
                xfer_ack = 1'b0;
                xfer_rx  = 8'hFF;
            end
        end
    end

    // Driver: pushes the expected byte stream and result, runs one command.
    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                           input logic crc, input logic lng, input logic [7:0] crc_byte,
                           input logic stray_start);
        int polls = 8;
        logic [7:0] exp_r1 = 8'hFF;
        logic [1:0] exp_cls;
        logic [31:0] exp_resp = 32'd0;
        logic extra;
        for (int k = 1; k < 8; k++) begin
            if (k < script_len && !script[k][7] && exp_r1 == 8'hFF) begin
                exp_r1 = script[k];
                polls = k + 1;
            end
        end
        if (exp_r1 == 8'hFF)      exp_cls = 2'd1;
        else if (exp_r1[3])       exp_cls = 2'd2;
        else if (|exp_r1[7:1])    exp_cls = 2'd3;
        else                      exp_cls = 2'd0;
        extra = lng && exp_r1 != 8'hFF && exp_r1[7:1] == 7'd0;
        if (extra)
            for (int k = 0; k < 4; k++) exp_resp = {exp_resp[23:0], script[polls+k]};

        push(1'b1, 8'hFF, "R2 lead byte");
        push(1'b1, {2'b01, idx}, "R2 index byte");
        for (int k = 0; k < 4; k++) push(1'b1, arg[31-8*k -: 8], "R2 arg byte");
        push(1'b1, crc_byte, crc ? "R3 crc byte" : "R4 fixed crc");
        for (int k = 0; k < polls; k++) push(1'b1, 8'hFF, "R5 poll byte");
        if (extra) for (int k = 0; k < 4; k++) push(1'b1, 8'hFF, "R8 extra byte");
        push(1'b0, 8'hFF, "R9 tail byte");

        @(negedge clk);
        start = 1'b1; cmd_index = idx; cmd_arg = arg; crc_on = crc; long_resp = lng;
        @(negedge clk);
        start = 1'b0;
        if (stray_start) begin
            repeat (5) @(negedge clk);
            start = 1'b1; cmd_index = 6'h3F; cmd_arg = 32'hDEADBEEF; crc_on = ~crc;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk("R6 r1", {24'd0, r1}, {24'd0, exp_r1});
        chk("R7 class", {30'd0, err_class}, {30'd0, exp_cls});
        chk("R8 resp word", resp_word, exp_resp);
        chk("R9 stream complete", exp_q.size(), 0);
        @(negedge clk);
        chk("R9 done single", {31'd0, done}, 32'd0);
    endtask

    task automatic set_script(input logic [7:0] s [12], input int n);
        for (int k = 0; k < 12; k++) script[k] = s[k];
        script_len = n;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 10; k++) push(1'b0, 8'hFF, "R1 preamble byte");
        repeat (3) @(negedge clk);
        chk("R1 reset ready", {31'd0, ready}, 0);
        chk("R1 reset done", {31'd0, done}, 0);
        rst_n = 1'b1;
        while (!ready) @(negedge clk);
        chk("R1 preamble consumed", exp_q.size(), 0);
        chk("R1 ready idle", {31'd0, ready}, 1);

        // CMD0, fixed CRC, first polled byte 0x00 must be skipped (R5)
        set_script('{8'h00, 8'h01, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 2);
        run_cmd(6'd0, 32'd0, 1'b0, 1'b0, 8'h95, 1'b0);

        // CMD8 with computed CRC and long reply (R3, R8)
        set_script('{8'hFF, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h01, 8'hAA, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 7);
        run_cmd(6'd8, 32'h0000_01AA, 1'b1, 1'b1, 8'h87, 1'b0);

        // CMD58 with computed CRC, R1 = 0x00, long reply (R3, R8)
        set_script('{8'hFF, 8'h00, 8'hC0, 8'hFF, 8'h80, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 6);
        run_cmd(6'd58, 32'd0, 1'b1, 1'b1, 8'hFD, 1'b0);

        // No reply at all: timeout (R6), fixed CRC on non-zero index (R4)
        set_script('{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 12);
        run_cmd(6'd55, 32'd0, 1'b0, 1'b0, 8'h95, 1'b0);

        // CRC fault with long selected: no extra bytes (R7, R8)
        set_script('{8'hFF, 8'h09, 8'h11, 8'h22, 8'h33, 8'h44, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 6);
        run_cmd(6'd8, 32'h0000_01AA, 1'b0, 1'b1, 8'h95, 1'b0);

        // Other fault, stray start while busy (R7, R10)
        set_script('{8'hFF, 8'hFF, 8'hFF, 8'h04, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 4);
        run_cmd(6'd17, 32'h1234_5678, 1'b0, 1'b0, 8'h95, 1'b1);

        // R1 only on the last allowed poll (R5, R6)
        set_script('{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 8);
        run_cmd(6'd16, 32'h0000_0200, 1'b0, 1'b0, 8'h95, 1'b0);

        // Bit-7-set non-0xFF bytes skipped; CRC bit wins over others (R5, R7)
        set_script('{8'hFF, 8'h80, 8'hFE, 8'h0D, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 4);
        run_cmd(6'd24, 32'h0000_1000, 1'b0, 1'b0, 8'h95, 1'b0);

        repeat (10) @(negedge clk);
        chk("R10 no trailing bytes", exp_q.size(), 0);
        chk("R1 back to ready", {31'd0, ready}, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule